// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Coherence Controller

This block manages the private, direct-mapped cache of one processor on a shared bus. It keeps every line in one of three coherence states, Invalid, Shared or Exclusive, and follows a write-invalidate policy. A processor may write a line only while it holds that line Exclusive. Reads and writes that hit are served locally. Misses and upgrades go through a bus request/grant handshake and issue read-miss, write-miss and write-back commands. An Exclusive victim is always written back before the line is refilled.

The same controller also watches the commands that other caches put on the bus. A snooped read miss that matches an Exclusive line makes the controller drive the word back out and demote the line to Shared. A snooped write miss that matches removes the local copy, and an Exclusive copy is flushed first. Snoops take precedence over a waiting processor request. A processor transaction that is still waiting for the bus is evaluated again after any snoop, because the snoop may have changed the line it was about to use.

The controller state machine has five states. ST_IDLE serves hits and snoops. ST_REQ waits for the grant. ST_WB drives the victim write-back for one cycle. ST_MISS drives the read or write miss, and an upgrade finishes here. ST_FILL waits for the fill word. The transitions are:
- ST_IDLE to ST_REQ on a miss or on a write to a Shared line.
- ST_REQ back to ST_IDLE on a snoop.
- ST_REQ to ST_WB (dirty victim) or to ST_MISS once the grant is seen.
- ST_WB to ST_MISS.
- ST_MISS to ST_IDLE for an upgrade, or to ST_FILL otherwise.
- ST_FILL to ST_IDLE when the fill arrives.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_ready, bus_req, bus_cmd_o and snp_supply_o are low, and the first read of any address issues a bus read miss.
- R2: A read that hits a Shared or Exclusive line raises cpu_ready for one cycle on the clock edge after the request, with the cached word on cpu_rdata, and issues no bus command.
- R3: A read miss issues command 1 (read miss) with the requested address. The word on fill_data_i is returned on cpu_rdata, and the line becomes Shared.
- R4: On a miss whose victim line is Exclusive, command 3 (write-back) carrying the victim address (victim tag above the index bits) and its data is issued before the miss command. A Shared or Invalid victim produces no write-back.
- R5: A write that hits an Exclusive line updates the word locally with no bus command.
- R6: A write that hits a Shared line issues command 2 (write miss) and completes without waiting for a fill. The line becomes Exclusive and holds the written word.
- R7: A write miss issues command 2, waits for the fill, and leaves the line Exclusive with the written word.
- R8: A snooped read miss (snp_cmd_i = 1) to an Exclusive line raises snp_supply_o for one cycle with the line's word and demotes the line to Shared. A snooped read miss to a Shared line has no effect.
- R9: A snooped write miss (snp_cmd_i = 2) to a Shared line invalidates it without supplying. To an Exclusive line, it supplies the word and then invalidates the line.
- R10: A snoop matches only when the index (address bits 3:0) and the tag (the bits above) both match a line that is not Invalid.
- R11: bus_cmd_o is non-zero only while bus_gnt is high. bus_req stays high from the grant wait until the last command of a processor transaction and its fill are complete.
- R12: A snoop arriving in the same cycle as a processor request is handled first. cpu_ready is pulsed only after every bus command of the request is complete, never while bus_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address: index in bits 3:0, tag above |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of the issued command |
| bus_data_o | output | DATA_W | Write-back data |
| fill_valid_i | input | 1 | Fill word valid |
| fill_data_i | input | DATA_W | Fill word |
| snp_cmd_i | input | 2 | Command issued by another cache, same encoding |
| snp_addr_i | input | ADDR_W | Address of the snooped command |
| snp_supply_o | output | 1 | This cache drives a block for the snoop |
| snp_data_o | output | DATA_W | Block supplied for the snoop |

## Verification
Every one of the 16 indexes runs the same six-step pattern:
1. A cold read.
2. A repeated read.
3. A write to the Shared line.
4. A second write.
5. A read of a conflicting tag.
6. A write to the first tag again.

Counting bus commands per step separates hits from misses and upgrades. It also separates a dirty victim from a clean one. Snoop patterns then target lines in each state and lines with a wrong tag. A following processor access exposes the resulting state through its bus traffic. The patterns are: a read-miss snoop to an Exclusive line and to a Shared line, a write-miss snoop to each, a snoop to an Invalid line, and a snoop to a wrong tag. Two races complete the set. One is a snoop in the same cycle as a request. The other is a snoop that flushes a victim while the grant is withheld, which must cancel the write-back.

// File: rtl/snc_pkg.sv
package snc_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WB,
        ST_MISS,
        ST_FILL
    } ctl_st_t;
endpackage

// File: rtl/snc_line_store.sv
module snc_line_store
    import snc_pkg::*;
#(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] a_idx,
    output line_st_t           a_st,
    output logic [TAG_W-1:0]   a_tag,
    output logic [DATA_W-1:0]  a_data,
    input  logic [INDEX_W-1:0] b_idx,
    output line_st_t           b_st,
    output logic [TAG_W-1:0]   b_tag,
    output logic [DATA_W-1:0]  b_data,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  line_st_t           fill_st,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               snp_en,
    input  logic [INDEX_W-1:0] snp_idx,
    input  line_st_t           snp_st
);
    localparam int LINES = 1 << INDEX_W;

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Coherence state: the only array that needs a reset value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
        end else begin
            if (fill_en) st_q[fill_idx] <= fill_st;
            if (snp_en)  st_q[snp_idx]  <= snp_st;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_tag;
            data_q[fill_idx] <= fill_data;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];
endmodule

// File: rtl/snc_tag_match.sv
module snc_tag_match
    import snc_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  line_st_t         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit,
    output logic             excl
);
    assign hit  = (st != LS_INV) && (line_tag == req_tag);
    assign excl = (st == LS_EXC);
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import snc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              fill_valid_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    output logic              snp_supply_o,
    output logic [DATA_W-1:0] snp_data_o
);
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int PORTS = 2;  // 0: processor lookup, 1: snoop lookup

    ctl_st_t state_q, state_d;

    logic [INDEX_W-1:0] lk_idx  [PORTS];
    logic [TAG_W-1:0]   lk_req  [PORTS];
    line_st_t           lk_st   [PORTS];
    logic [TAG_W-1:0]   lk_tag  [PORTS];
    logic [DATA_W-1:0]  lk_data [PORTS];
    logic [PORTS-1:0]   lk_hit, lk_excl;

    assign lk_idx[0] = cpu_addr[INDEX_W-1:0];
    assign lk_req[0] = cpu_addr[ADDR_W-1:INDEX_W];
    assign lk_idx[1] = snp_addr_i[INDEX_W-1:0];
    assign lk_req[1] = snp_addr_i[ADDR_W-1:INDEX_W];

    // Line store write controls
    logic               fill_en, snp_en;
    line_st_t           fill_st, snp_st;
    logic [DATA_W-1:0]  fill_word;

    snc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (lk_idx[0]),
        .a_st     (lk_st[0]),
        .a_tag    (lk_tag[0]),
        .a_data   (lk_data[0]),
        .b_idx    (lk_idx[1]),
        .b_st     (lk_st[1]),
        .b_tag    (lk_tag[1]),
        .b_data   (lk_data[1]),
        .fill_en  (fill_en),
        .fill_idx (lk_idx[0]),
        .fill_st  (fill_st),
        .fill_tag (lk_req[0]),
        .fill_data(fill_word),
        .snp_en   (snp_en),
        .snp_idx  (lk_idx[1]),
        .snp_st   (snp_st)
    );

    for (genvar g = 0; g < PORTS; g++) begin : g_match
        snc_tag_match #(.TAG_W(TAG_W)) u_match (
            .st      (lk_st[g]),
            .line_tag(lk_tag[g]),
            .req_tag (lk_req[g]),
            .hit     (lk_hit[g]),
            .excl    (lk_excl[g])
        );
    end

    // Snoop decode: only while another cache may own the bus
    bus_cmd_t snp_cmd;
    logic     snp_seen, snp_flush;
    assign snp_cmd   = bus_cmd_t'(snp_cmd_i);
    assign snp_seen  = (state_q == ST_IDLE || state_q == ST_REQ) && (snp_cmd != BC_NONE);
    assign snp_flush = snp_seen && lk_hit[1] && lk_excl[1] &&
                       (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS);
    assign snp_en    = snp_seen && lk_hit[1] &&
                       ((snp_cmd == BC_RDMISS && lk_excl[1]) || snp_cmd == BC_WRMISS);
    assign snp_st    = (snp_cmd == BC_RDMISS) ? LS_SHR : LS_INV;

    // Processor side decode
    logic cpu_go, local_done, upgrade_done, fill_done;
    assign cpu_go       = (state_q == ST_IDLE) && cpu_req && !snp_seen;
    assign local_done   = cpu_go && lk_hit[0] && (!cpu_we || lk_excl[0]);
    assign upgrade_done = (state_q == ST_MISS) && bus_gnt && lk_hit[0];
    assign fill_done    = (state_q == ST_FILL) && fill_valid_i;

    assign fill_en   = fill_done || upgrade_done || (local_done && cpu_we);
    assign fill_st   = cpu_we ? LS_EXC : LS_SHR;
    assign fill_word = cpu_we ? cpu_wdata : fill_data_i;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_go && !local_done) state_d = ST_REQ;
            ST_REQ: begin
                if (snp_seen)     state_d = ST_IDLE;
                else if (bus_gnt) state_d = (!lk_hit[0] && lk_excl[0]) ? ST_WB : ST_MISS;
            end
            ST_WB:   if (bus_gnt) state_d = ST_MISS;
            ST_MISS: if (bus_gnt) state_d = lk_hit[0] ? ST_IDLE : ST_FILL;
            ST_FILL: if (fill_valid_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bus outputs
    always_comb begin
        bus_req    = (state_q != ST_IDLE);
        bus_cmd_o  = BC_NONE;
        bus_addr_o = cpu_addr;
        bus_data_o = cpu_wdata;
        unique case (state_q)
            ST_WB: if (bus_gnt) begin
                bus_cmd_o  = BC_WBACK;
                bus_addr_o = {lk_tag[0], lk_idx[0]};
                bus_data_o = lk_data[0];
            end
            ST_MISS: if (bus_gnt) bus_cmd_o = cpu_we ? BC_WRMISS : BC_RDMISS;
            default: ;
        endcase
    end

    // Registered responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_ready    <= 1'b0;
            cpu_rdata    <= '0;
            snp_supply_o <= 1'b0;
            snp_data_o   <= '0;
        end else begin
            cpu_ready    <= local_done || upgrade_done || fill_done;
            if (local_done && !cpu_we)     cpu_rdata <= lk_data[0];
            else if (fill_done && !cpu_we) cpu_rdata <= fill_data_i;
            snp_supply_o <= snp_flush;
            if (snp_flush) snp_data_o <= lk_data[1];
        end
    end
endmodule

// File: rtl/snc_checker.sv
module snc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_ready,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd_o,
    input logic [1:0] snp_cmd_i,
    input logic       snp_supply_o
);
    assert_cmd_needs_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o != 2'd0) |-> bus_gnt);

    assert_writeback_keeps_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_o == 2'd3) |=> bus_req);

    assert_ready_after_bus_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    assert_ready_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(cpu_req));

    assert_supply_follows_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply_o |-> $past(snp_cmd_i != 2'd0));
endmodule

bind snoop_cache_ctrl snc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_ready   (cpu_ready),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd_o   (bus_cmd_o),
    .snp_cmd_i   (snp_cmd_i),
    .snp_supply_o(snp_supply_o)
);

// File: tb/sim_snoop_cache_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_cache_ctrl;
    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic cpu_ready, bus_req;
    logic bus_gnt = 1'b0;
    logic [1:0] bus_cmd_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_data_o;
    logic fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic [1:0] snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_supply_o;
    logic [DW-1:0] snp_data_o;

    always #2 clk = ~clk;

    snoop_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_o(bus_cmd_o),
        .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
        .fill_valid_i(fill_valid), .fill_data_i(fill_data),
        .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .snp_supply_o(snp_supply_o), .snp_data_o(snp_data_o)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // Memory, arbiter and bus monitor models
    logic [DW-1:0] mem [1 << AW];
    logic block_gnt = 1'b0;
    int n_rd = 0, n_wr = 0, n_wb = 0;
    logic [AW-1:0] wb_addr = '0, snp_last = '0;
    logic [DW-1:0] wb_data = '0;

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        return 32'h5EED_0000 ^ (32'(a) * 32'd40503);
    endfunction

    function automatic logic [DW-1:0] wv(input int k, input int i);
        return 32'hA500_0000 | 32'(k << 8) | 32'(i);
    endfunction

    always @(posedge clk) begin
        bus_gnt    <= bus_req && !block_gnt;
        fill_valid <= 1'b0;
        if (bus_cmd_o == 2'd1 || bus_cmd_o == 2'd2) begin
            if (bus_cmd_o == 2'd1) n_rd++; else n_wr++;
            fill_valid <= 1'b1;
            fill_data  <= mem[bus_addr_o];
        end else if (bus_cmd_o == 2'd3) begin
            n_wb++;
            wb_addr <= bus_addr_o;
            wb_data <= bus_data_o;
            mem[bus_addr_o] <= bus_data_o;
        end
        if (snp_supply_o) mem[snp_last] <= snp_data_o;
        if (snp_cmd != 2'd0) snp_last <= snp_addr;
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    int dr, dw, db;
    logic [DW-1:0] rd;

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        int r0, w0, b0;
        bit got;
        r0 = n_rd; w0 = n_wr; b0 = n_wb;
        got = 1'b0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        for (int t = 0; t < 100 && !got; t++) begin
            @(negedge clk);
            if (cpu_ready) got = 1'b1;
        end
        cpu_req = 1'b0;
        chk(got, "R12 ready", 32'(got), 32'd1);
        rd = cpu_rdata;
        dr = n_rd - r0; dw = n_wr - w0; db = n_wb - b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         input bit exp_sup, input logic [DW-1:0] exp_d, input string req);
        @(negedge clk);
        snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_cmd = 2'd0;
        chk(snp_supply_o == exp_sup, req, 32'(snp_supply_o), 32'(exp_sup));
        if (exp_sup) chk(snp_data_o == exp_d, req, snp_data_o, exp_d);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < (1 << AW); a++) mem[a] = memval(AW'(a));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!cpu_ready && !bus_req && bus_cmd_o == 2'd0 && !snp_supply_o, "R1 reset outputs",
            {28'd0, cpu_ready, bus_req, bus_cmd_o != 2'd0, snp_supply_o}, 32'd0);

        // Per-index sweep: A = tag 1, B = tag 2
        for (int i = 0; i < 16; i++) begin
            logic [AW-1:0] aa, bb;
            aa = AW'(16 + i);
            bb = AW'(32 + i);
            cpu_op(1'b0, aa, '0);  // R1/R3 cold read miss
            chk(dr == 1 && dw == 0 && db == 0, "R1 R3 cold read miss", 32'(dr), 32'd1);
            chk(rd == memval(aa), "R3 fill data", rd, memval(aa));
            cpu_op(1'b0, aa, '0);  // R2 read hit
            chk(dr + dw + db == 0, "R2 read hit no bus", 32'(dr + dw + db), 32'd0);
            chk(rd == memval(aa), "R2 read hit data", rd, memval(aa));
            cpu_op(1'b1, aa, wv(1, i));  // R6 upgrade
            chk(dw == 1 && dr == 0 && db == 0, "R6 upgrade write miss", 32'(dw), 32'd1);
            cpu_op(1'b1, aa, wv(2, i));  // R5 exclusive hit
            chk(dr + dw + db == 0, "R5 exclusive write no bus", 32'(dr + dw + db), 32'd0);
            cpu_op(1'b0, aa, '0);
            chk(rd == wv(2, i) && dr + dw + db == 0, "R5 written word read back", rd, wv(2, i));
            cpu_op(1'b0, bb, '0);  // R4 dirty victim
            chk(db == 1 && dr == 1, "R4 dirty victim write-back", 32'(db), 32'd1);
            chk(wb_addr == aa && wb_data == wv(2, i), "R4 write-back addr/data", wb_data, wv(2, i));
            chk(rd == memval(bb), "R3 conflict fill data", rd, memval(bb));
            cpu_op(1'b1, aa, wv(3, i));  // R7 write miss, clean victim
            chk(dw == 1 && dr == 0 && db == 0, "R7 write miss clean victim R4", 32'(db), 32'd0);
            cpu_op(1'b0, aa, '0);
            chk(rd == wv(3, i) && dr + dw + db == 0, "R7 line exclusive with write", rd, wv(3, i));
        end

        // Snoop patterns on index 0
        snoop(2'd1, AW'(48), 1'b0, '0, "R10 wrong tag no supply");
        cpu_op(1'b1, AW'(16), wv(4, 0));
        chk(dr + dw + db == 0, "R10 line still exclusive", 32'(dr + dw + db), 32'd0);
        snoop(2'd1, AW'(16), 1'b1, wv(4, 0), "R8 read snoop exclusive supplies");
        cpu_op(1'b1, AW'(16), wv(5, 0));
        chk(dw == 1 && dr == 0, "R8 demoted to shared", 32'(dw), 32'd1);
        snoop(2'd2, AW'(16), 1'b1, wv(5, 0), "R9 write snoop exclusive flushes");
        @(negedge clk);
        cpu_op(1'b0, AW'(16), '0);
        chk(dr == 1 && rd == wv(5, 0), "R9 exclusive invalidated", rd, wv(5, 0));
        snoop(2'd1, AW'(16), 1'b0, '0, "R8 read snoop shared silent");
        cpu_op(1'b0, AW'(16), '0);
        chk(dr + dw + db == 0, "R8 shared kept", 32'(dr + dw + db), 32'd0);
        snoop(2'd2, AW'(16), 1'b0, '0, "R9 write snoop shared silent");
        cpu_op(1'b0, AW'(16), '0);
        chk(dr == 1, "R9 shared invalidated", 32'(dr), 32'd1);

        // R10: snoop to an Invalid line
        snoop(2'd2, AW'(17), 1'b1, wv(3, 1), "R9 flush index 1");
        snoop(2'd2, AW'(17), 1'b0, '0, "R10 invalid line no supply");

        // R12: snoop and request in the same cycle
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(18);
        snp_cmd = 2'd2; snp_addr = AW'(18);
        begin
            int r0;
            bit got;
            r0 = n_rd;
            got = 1'b0;
            @(negedge clk);
            snp_cmd = 2'd0;
            chk(snp_supply_o && !cpu_ready, "R12 snoop served first", 32'(snp_supply_o), 32'd1);
            chk(snp_data_o == wv(3, 2), "R12 snoop data", snp_data_o, wv(3, 2));
            for (int t = 0; t < 100 && !got; t++) begin
                @(negedge clk);
                if (cpu_ready) got = 1'b1;
            end
            cpu_req = 1'b0;
            chk(got && n_rd - r0 == 1 && cpu_rdata == wv(3, 2), "R12 request replayed as miss", cpu_rdata, wv(3, 2));
        end

        // R11: grant withheld, snoop cancels the dirty victim's write-back (R4)
        repeat (3) @(negedge clk);
        block_gnt = 1'b1;
        begin
            int r0, b0;
            bit got;
            r0 = n_rd; b0 = n_wb;
            got = 1'b0;
            @(negedge clk);
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(35);
            repeat (4) @(negedge clk);
            chk(bus_req && !cpu_ready && bus_cmd_o == 2'd0, "R11 waits for grant", 32'(bus_req), 32'd1);
            snp_cmd = 2'd2; snp_addr = AW'(19);
            @(negedge clk);
            snp_cmd = 2'd0;
            chk(snp_supply_o && snp_data_o == wv(3, 3), "R12 snoop during grant wait", snp_data_o, wv(3, 3));
            block_gnt = 1'b0;
            for (int t = 0; t < 100 && !got; t++) begin
                @(negedge clk);
                if (cpu_ready) got = 1'b1;
            end
            cpu_req = 1'b0;
            chk(got && n_wb == b0 && n_rd - r0 == 1, "R4 victim invalidated, no write-back", 32'(n_wb - b0), 32'd0);
            chk(cpu_rdata == memval(AW'(35)), "R3 fill after grant", cpu_rdata, memval(AW'(35)));
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule